// File: doc/BRIEF.md
# SONET Transmit Overhead Inserter

This block handles the byte-wide transmit path of one STS-12 channel. It takes one data byte per clock with a parity bit and a one-cycle frame marker. It checks the parity of each incoming byte and writes the row-1 framing pattern into each frame. That pattern can be corrupted on purpose for link testing. The block places the bit-interleaved parity of the previous frame into the B1 byte, and it applies the frame-synchronous scrambler to the rest of the frame. Every byte leaves one clock after it arrives, together with a marker for the first byte of the frame.

Each processing stage has its own enable, so the stages can be switched off one at a time. With every enable low, the byte stream leaves the block unchanged, one cycle late. A sticky alarm records input parity mismatches until a clear strobe arrives. The frame layout is 9 rows of 1080 bytes. The byte counter aligns itself to the frame marker, and after that it runs freely.

Top module: `sts_oh_inserter`

## Requirements
- R1: `frame_sync` marks byte position 0 of a frame. With no pulse, the position counts up and wraps to 0 after 9720 bytes. A pulse in mid-frame forces position 0 again. Every output lags its input byte by one clock, and `dout_sof` is high exactly for the output of position 0.
- R2: With `cfg_frm_en` high and `cfg_err_ins` low, output positions 0–11 are 0xF6 and positions 12–23 are 0x28.
- R3: With `cfg_frm_en` and `cfg_err_ins` both high, bit 0 of each of those 24 bytes is inverted (0xF7, 0x29). With `cfg_frm_en` low, `cfg_err_ins` has no effect.
- R4: With `cfg_b1_en` high, the byte at position 1080 is replaced by the XOR of all output bytes from the previous frame start up to the current one. For the first frame, the XOR covers all output bytes since reset. With `cfg_b1_en` low, the input byte is kept.
- R5: With `cfg_scr_en` high, positions 24 through 9719 are XORed with the 1 + x^6 + x^7 sequence, most significant bit first. The sequence is restarted at all ones at position 24, so the first mask byte is 0xFE and the second is 0x04. Positions 0–23 are never scrambled.
- R6: With all three stage enables low, `dout` equals the previous cycle's `din`. Before the first `frame_sync` after reset, no stage alters the data.
- R7: A byte whose XOR over `din` and `din_par` differs from `cfg_par_odd` (1 selects odd parity) sets `par_alarm` on the next clock.
- R8: `par_alarm` stays set until `alarm_clr` is high. A mismatch in the same cycle as the clear keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Transmit data byte |
| din_par | input | 1 | Parity bit for `din` |
| frame_sync | input | 1 | One-cycle marker of frame position 0 |
| cfg_par_odd | input | 1 | 1 = odd parity expected, 0 = even |
| cfg_frm_en | input | 1 | Enable framing pattern insertion |
| cfg_err_ins | input | 1 | Corrupt the framing pattern |
| cfg_b1_en | input | 1 | Enable B1 insertion |
| cfg_scr_en | input | 1 | Enable scrambling |
| alarm_clr | input | 1 | Clear strobe for `par_alarm` |
| dout | output | 8 | Processed byte, one cycle after input |
| dout_sof | output | 1 | High with the output of position 0 |
| par_alarm | output | 1 | Sticky parity alarm |

## Verification
A wrong frame position shows within one frame. Framing bytes appear on the wrong cycles, or `dout_sof` stops following the marker by one clock. A fault in the scrambler state corrupts the very next byte after position 24. A fault in the parity accumulator shows only at position 1080 of the next frame, roughly a frame and a tenth after the fault. For that reason the bench compares every output byte against an independent reference across consecutive frames, including a frame that wraps without a marker and a realignment. A faulty alarm path shows one clock after the offending byte or the clear.

// File: rtl/sts_oh_pkg.sv
package sts_oh_pkg;

    localparam logic [7:0] FRAME_A1 = 8'hF6;
    localparam logic [7:0] FRAME_A2 = 8'h28;
    localparam logic [6:0] SCR_SEED = 7'h7F;

    typedef enum logic [1:0] {
        SLOT_DATA,
        SLOT_A1,
        SLOT_A2,
        SLOT_B1
    } slot_e;

    typedef struct packed {
        logic frm_en;
        logic err_ins;
        logic b1_en;
        logic scr_en;
    } stage_ctl_t;

    typedef struct packed {
        logic [7:0] data;
        logic       sof;
    } out_beat_t;

    typedef struct packed {
        logic [7:0] mask;
        logic [6:0] next;
    } scr_step_t;

    // Eight steps of the 1 + x^6 + x^7 generator, first bit to the MSB.
    function automatic scr_step_t scr_advance(input logic [6:0] state);
        scr_step_t  r;
        logic [6:0] st;
        st = state;
        r.mask = '0;
        for (int i = 7; i >= 0; i--) begin
            r.mask[i] = st[6];
            st = {st[5:0], st[6] ^ st[5]};
        end
        r.next = st;
        return r;
    endfunction

    function automatic logic parity_bad(input logic [7:0] d, input logic p,
                                        input logic odd_sel);
        return (^{d, p}) != odd_sel;
    endfunction

endpackage

// File: rtl/sts_frame_tracker.sv
module sts_frame_tracker
    import sts_oh_pkg::*;
#(
    parameter int ROW_LEN = 1080,
    parameter int ROWS    = 9,
    parameter int N_INTLV = 12
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_sync,
    output slot_e slot,
    output logic  sof,
    output logic  scr_zone,
    output logic  scr_seed
);
    localparam int FRAME_LEN = ROW_LEN * ROWS;
    localparam int CW        = $clog2(FRAME_LEN);
    localparam logic [CW-1:0] POS_LAST = CW'(FRAME_LEN - 1);
    localparam logic [CW-1:0] A1_END   = CW'(N_INTLV);
    localparam logic [CW-1:0] A2_END   = CW'(2 * N_INTLV);
    localparam logic [CW-1:0] B1_POS   = CW'(ROW_LEN);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cur_pos;
    logic [CW-1:0] cnt_d;
    logic          aligned_q;
    logic          live;

    assign live    = aligned_q | frame_sync;
    assign cur_pos = frame_sync ? '0 : cnt_q;
    assign cnt_d   = (cur_pos == POS_LAST) ? '0 : cur_pos + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            aligned_q <= 1'b0;
        end else begin
            aligned_q <= live;
            cnt_q     <= live ? cnt_d : '0;
        end
    end

    always_comb begin
        slot = SLOT_DATA;
        if (live) begin
            if (cur_pos < A1_END)       slot = SLOT_A1;
            else if (cur_pos < A2_END)  slot = SLOT_A2;
            else if (cur_pos == B1_POS) slot = SLOT_B1;
        end
    end

    assign sof      = live && (cur_pos == '0);
    assign scr_zone = live && (cur_pos >= A2_END);
    assign scr_seed = live && (cur_pos == A2_END);

endmodule

// File: rtl/sts_overhead_mux.sv
module sts_overhead_mux
    import sts_oh_pkg::*;
(
    input  logic [7:0] din,
    input  slot_e      slot,
    input  stage_ctl_t ctl,
    input  logic [7:0] b1_val,
    output logic [7:0] dout
);
    logic [7:0] err_mask;

    assign err_mask = {7'b0, ctl.err_ins};

    always_comb begin
        dout = din;
        unique case (slot)
            SLOT_A1:   if (ctl.frm_en) dout = FRAME_A1 ^ err_mask;
            SLOT_A2:   if (ctl.frm_en) dout = FRAME_A2 ^ err_mask;
            SLOT_B1:   if (ctl.b1_en)  dout = b1_val;
            default:   dout = din;
        endcase
    end

endmodule

// File: rtl/sts_scrambler.sv
module sts_scrambler
    import sts_oh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] din,
    input  logic       seed,
    input  logic       zone,
    input  logic       en,
    output logic [7:0] dout
);
    logic [6:0] state_q;
    logic [6:0] state_use;
    scr_step_t  step;

    assign state_use = seed ? SCR_SEED : state_q;
    assign step      = scr_advance(state_use);
    assign dout      = (en && zone) ? (din ^ step.mask) : din;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SCR_SEED;
        else     state_q <= step.next;
    end

endmodule

// File: rtl/sts_b1_calc.sv
module sts_b1_calc (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] tx_byte,
    input  logic       sof,
    output logic [7:0] b1_val
);
    logic [7:0] acc_q;
    logic [7:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            hold_q <= '0;
        end else if (sof) begin
            hold_q <= acc_q;
            acc_q  <= tx_byte;
        end else begin
            acc_q  <= acc_q ^ tx_byte;
        end
    end

    assign b1_val = hold_q;

endmodule

// File: rtl/sts_parity_mon.sv
module sts_parity_mon
    import sts_oh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] din,
    input  logic       din_par,
    input  logic       odd_sel,
    input  logic       clr,
    output logic       alarm
);
    logic alarm_q;
    logic hit;

    assign hit = parity_bad(din, din_par, odd_sel);

    always_ff @(posedge clk) begin
        if (rst) alarm_q <= 1'b0;
        else     alarm_q <= hit | (alarm_q & ~clr);
    end

    assign alarm = alarm_q;

endmodule

// File: rtl/sts_oh_inserter.sv
module sts_oh_inserter
    import sts_oh_pkg::*;
#(
    parameter int ROW_LEN       = 1080,
    parameter int ROWS          = 9,
    parameter int N_INTLV       = 12,
    parameter bit USE_SCRAMBLER = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] din,
    input  logic       din_par,
    input  logic       frame_sync,
    input  logic       cfg_par_odd,
    input  logic       cfg_frm_en,
    input  logic       cfg_err_ins,
    input  logic       cfg_b1_en,
    input  logic       cfg_scr_en,
    input  logic       alarm_clr,
    output logic [7:0] dout,
    output logic       dout_sof,
    output logic       par_alarm
);
    stage_ctl_t ctl;
    slot_e      slot;
    logic       sof;
    logic       scr_zone;
    logic       scr_seed;
    logic [7:0] b1_val;
    logic [7:0] ovh_byte;
    logic [7:0] tx_byte;
    out_beat_t  beat_q;

    assign ctl = '{frm_en: cfg_frm_en, err_ins: cfg_err_ins,
                   b1_en: cfg_b1_en, scr_en: cfg_scr_en};

    sts_frame_tracker #(
        .ROW_LEN (ROW_LEN),
        .ROWS    (ROWS),
        .N_INTLV (N_INTLV)
    ) tracker_i (
        .clk        (clk),
        .rst        (rst),
        .frame_sync (frame_sync),
        .slot       (slot),
        .sof        (sof),
        .scr_zone   (scr_zone),
        .scr_seed   (scr_seed)
    );

    sts_overhead_mux ovh_i (
        .din    (din),
        .slot   (slot),
        .ctl    (ctl),
        .b1_val (b1_val),
        .dout   (ovh_byte)
    );

    generate
        if (USE_SCRAMBLER) begin : g_scr
            sts_scrambler scr_i (
                .clk  (clk),
                .rst  (rst),
                .din  (ovh_byte),
                .seed (scr_seed),
                .zone (scr_zone),
                .en   (ctl.scr_en),
                .dout (tx_byte)
            );
        end else begin : g_noscr
            assign tx_byte = ovh_byte;
        end
    endgenerate

    sts_b1_calc b1_i (
        .clk     (clk),
        .rst     (rst),
        .tx_byte (tx_byte),
        .sof     (sof),
        .b1_val  (b1_val)
    );

    sts_parity_mon par_i (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .din_par (din_par),
        .odd_sel (cfg_par_odd),
        .clr     (alarm_clr),
        .alarm   (par_alarm)
    );

    always_ff @(posedge clk) begin
        if (rst) beat_q <= '0;
        else     beat_q <= '{data: tx_byte, sof: sof};
    end

    assign dout     = beat_q.data;
    assign dout_sof = beat_q.sof;

endmodule

// File: rtl/sts_oh_inserter_chk.sv
module sts_oh_inserter_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] din,
    input logic       din_par,
    input logic       frame_sync,
    input logic       cfg_par_odd,
    input logic       cfg_frm_en,
    input logic       cfg_err_ins,
    input logic       cfg_b1_en,
    input logic       cfg_scr_en,
    input logic       alarm_clr,
    input logic [7:0] dout,
    input logic       dout_sof,
    input logic       par_alarm
);
    // R1
    sof_follows_sync_chk: assert property (@(posedge clk) disable iff (rst)
        frame_sync |=> dout_sof);

    // R2
    a1_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        frame_sync && cfg_frm_en && !cfg_err_ins |=> dout == 8'hF6);

    // R3
    a1_corrupt_chk: assert property (@(posedge clk) disable iff (rst)
        frame_sync && cfg_frm_en && cfg_err_ins |=> dout == 8'hF7);

    // R6
    full_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_frm_en && !cfg_b1_en && !cfg_scr_en |=> dout == $past(din));

    // R7
    parity_raise_chk: assert property (@(posedge clk) disable iff (rst)
        ((^{din, din_par}) != cfg_par_odd) |=> par_alarm);

    // R8
    alarm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        par_alarm && !alarm_clr |=> par_alarm);

    // R8
    alarm_release_chk: assert property (@(posedge clk) disable iff (rst)
        par_alarm && alarm_clr && ((^{din, din_par}) == cfg_par_odd) |=> !par_alarm);

endmodule

bind sts_oh_inserter sts_oh_inserter_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .din         (din),
    .din_par     (din_par),
    .frame_sync  (frame_sync),
    .cfg_par_odd (cfg_par_odd),
    .cfg_frm_en  (cfg_frm_en),
    .cfg_err_ins (cfg_err_ins),
    .cfg_b1_en   (cfg_b1_en),
    .cfg_scr_en  (cfg_scr_en),
    .alarm_clr   (alarm_clr),
    .dout        (dout),
    .dout_sof    (dout_sof),
    .par_alarm   (par_alarm)
);

// File: tb/sts_oh_inserter_tb.sv
module sts_oh_inserter_tb_top;

    localparam int ROW_B   = 1080;
    localparam int FRAME_B = ROW_B * 9;
    localparam int NA      = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = '0;
    logic       din_par = 1'b0;
    logic       frame_sync = 1'b0;
    logic       par_odd = 1'b0;
    logic       frm_en = 1'b0;
    logic       err_ins = 1'b0;
    logic       b1_en = 1'b0;
    logic       scr_en = 1'b0;
    logic       alarm_clr = 1'b0;
    logic [7:0] dout;
    logic       dout_sof;
    logic       par_alarm;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference state
    bit         m_aligned = 0;
    int         m_pos = 0;
    logic [7:0] m_acc = '0;
    logic [7:0] m_hold = '0;
    bit         kq[$];
    logic       m_alarm = 1'b0;

    always #2 clk = ~clk;

    sts_oh_inserter dut_i (
        .clk         (clk),
        .rst         (rst),
        .din         (din),
        .din_par     (din_par),
        .frame_sync  (frame_sync),
        .cfg_par_odd (par_odd),
        .cfg_frm_en  (frm_en),
        .cfg_err_ins (err_ins),
        .cfg_b1_en   (b1_en),
        .cfg_scr_en  (scr_en),
        .alarm_clr   (alarm_clr),
        .dout        (dout),
        .dout_sof    (dout_sof),
        .par_alarm   (par_alarm)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic step(input logic [7:0] d, input bit bad_par, input bit sync, input bit clr);
        logic [7:0] b;
        logic [7:0] ks;
        bit         sof;
        string      tag;
        din        = d;
        din_par    = (^d) ^ par_odd ^ bad_par;
        frame_sync = sync;
        alarm_clr  = clr;
        if (sync) begin
            m_aligned = 1;
            m_pos = 0;
        end else if (m_aligned) begin
            m_pos = (m_pos == FRAME_B - 1) ? 0 : m_pos + 1;
        end
        b = d;
        tag = "R6";
        sof = 0;
        if (m_aligned) begin
            sof = (m_pos == 0);
            if (m_pos < 2 * NA) begin
                if (frm_en) begin
                    b = ((m_pos < NA) ? 8'hF6 : 8'h28) ^ {7'b0, err_ins};
                    tag = err_ins ? "R3" : "R2";
                end else if (err_ins) begin
                    tag = "R3";
                end
            end else if (m_pos == ROW_B && b1_en) begin
                b = m_hold;
                tag = "R4";
            end
            if (m_pos == 2 * NA) kq = '{1, 1, 1, 1, 1, 1, 1};
            if (m_pos >= 2 * NA) begin
                ks = '0;
                for (int i = 0; i < 8; i++) begin
                    ks = {ks[6:0], kq[0]};
                    kq.push_back(kq[0] ^ kq[1]);
                    void'(kq.pop_front());
                end
                if (scr_en) begin
                    b = b ^ ks;
                    if (tag == "R6") tag = "R5";
                end
            end
        end
        if (sof) begin
            m_hold = m_acc;
            m_acc  = b;
        end else begin
            m_acc = m_acc ^ b;
        end
        m_alarm = bad_par | (m_alarm & ~clr);
        @(posedge clk);
        @(negedge clk);
        check(tag, "dout", dout, b);
        check("R1", "dout_sof", dout_sof, sof);
        check(clr ? "R8" : "R7", "par_alarm", par_alarm, m_alarm);
    endtask

    task automatic run_bytes(input bit sync_first, input int n);
        for (int i = 0; i < n; i++) begin
            step(8'($urandom), (i % 997) == 500, sync_first && (i == 0), (i % 1499) == 3);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", "reset dout", dout, 0);
        check("R1", "reset sof", dout_sof, 0);
        check("R7", "reset alarm", par_alarm, 0);
        rst = 1'b0;
        frm_en = 1; b1_en = 1; scr_en = 1;
        run_bytes(0, 50);                    // R6: before first marker
        run_bytes(1, FRAME_B);               // R2, R5
        run_bytes(1, FRAME_B);               // R4 over first frame
        run_bytes(1, FRAME_B);
        err_ins = 1;
        run_bytes(1, FRAME_B);               // R3
        err_ins = 0;
        run_bytes(0, FRAME_B);               // R1: wrap without marker
        run_bytes(1, 500);                   // R1: early marker realigns
        run_bytes(1, FRAME_B);
        scr_en = 0;
        run_bytes(1, FRAME_B);               // R5 off, R4 unscrambled
        b1_en = 0;
        run_bytes(1, 2 * ROW_B);             // R4 disabled
        frm_en = 0; err_ins = 1;
        run_bytes(1, 2 * ROW_B);             // R3 ignored, R6 full bypass
        err_ins = 0;
        // R7, R8 directed sequence in odd parity
        par_odd = 1;
        step(8'h3C, 0, 0, 1);
        step(8'hA5, 1, 0, 0);
        step(8'h11, 0, 0, 0);
        step(8'h5A, 1, 0, 1);
        step(8'h00, 0, 0, 1);
        par_odd = 0;
        step(8'h81, 1, 0, 0);
        step(8'h7E, 0, 0, 1);
        step(8'hFF, 0, 0, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule